// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 64-bit HI/LO Accumulator

This unit executes the multiply group of a 32-bit RISC core's secondary arithmetic opcode space. It owns the 64-bit accumulator pair HI/LO. From a 6-bit function code it picks one of five operations. MUL returns the low word of a signed product for a general register. The other four multiply two operands, signed or unsigned, and add the full 64-bit product to {HI,LO} or subtract it from {HI,LO}.

Every accepted operation runs through a fixed three-cycle pipeline. While an operation is in flight the unit raises busy and ignores any new issue. Two direct write ports load HI or LO for move-to instructions. When a direct write lands in the same cycle as a completing accumulate, the accumulate takes precedence. The pipeline reads HI/LO in the cycle the operation completes, not in the cycle it was issued.

Top module: `mac_hilo_unit`

## Requirements
- R1: A synchronous active-high reset clears HI, LO and the result register to zero and deasserts busy.
- R2: Function code 000010 (MUL) writes the low 32 bits of the signed 64-bit product to `result_o`. The value appears after the third rising edge that follows the edge sampling the issue.
- R3: Function code 000000 adds the signed 64-bit product to {HI,LO}. HI holds bits 63:32 and LO holds bits 31:0.
- R4: Function code 000001 adds the unsigned 64-bit product to {HI,LO}.
- R5: Function code 000100 subtracts the signed 64-bit product from {HI,LO}.
- R6: Function code 000101 subtracts the unsigned 64-bit product from {HI,LO}.
- R7: Accumulation wraps modulo 2^64 with no exception or saturation. For example, all-ones plus 1 gives zero, and zero minus 1 gives all-ones.
- R8: After an accepted issue, busy is high for exactly 3 cycles. An issue sampled while busy is high is ignored and does not lengthen busy.
- R9: An issue with any other function code is ignored. Busy stays low and HI, LO and the result do not change.
- R10: When idle, `hi_wr_i` or `lo_wr_i` loads `hi_wdata_i` or `lo_wdata_i` into that half at the next edge. The other half is left unchanged.
- R11: If an accumulate completes in the same cycle as a direct HI/LO write, the accumulate result is stored and the direct write is lost.
- R12: Accumulate operations leave `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe for a new operation |
| func_i | input | 6 | Function code of the operation |
| rs_i | input | 32 | First operand |
| rt_i | input | 32 | Second operand |
| hi_wr_i | input | 1 | Direct write enable for HI |
| hi_wdata_i | input | 32 | Direct write data for HI |
| lo_wr_i | input | 1 | Direct write enable for LO |
| lo_wdata_i | input | 32 | Direct write data for LO |
| result_o | output | 32 | Low word of the last MUL product |
| hi_o | output | 32 | Current HI |
| lo_o | output | 32 | Current LO |
| busy_o | output | 1 | An operation is in flight |

## Verification
The bench feeds operands whose top bit is set, so a unit that confuses signed and unsigned extension produces a HI word that is off by an operand's magnitude. It pushes the accumulator across the 2^64 boundary in both directions, so a unit that loses the carry or borrow between LO and HI shows up at once. It also issues a second operation in the middle of a busy window, which catches a unit that restarts or extends its pipeline. It raises direct writes exactly on the completion edge, where the wrong priority would leave the written word in HI/LO. Finally it issues unused function codes, because a loose decoder would start a spurious operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [5:0] {
    FN_MADD  = 6'b000000,
    FN_MADDU = 6'b000001,
    FN_MUL   = 6'b000010,
    FN_MSUB  = 6'b000100,
    FN_MSUBU = 6'b000101
  } mac_fn_e;

  typedef struct packed {
    logic acc;   // 1: update HI/LO, 0: return low word
    logic sub;   // subtract product from accumulator
    logic sgn;   // operands are two's complement
  } mac_op_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [5:0] func,
  output logic       valid,
  output mac_op_t    op
);

  always_comb begin
    valid = 1'b1;
    op    = '0;
    case (func)
      FN_MADD:  op = '{acc: 1'b1, sub: 1'b0, sgn: 1'b1};
      FN_MADDU: op = '{acc: 1'b1, sub: 1'b0, sgn: 1'b0};
      FN_MUL:   op = '{acc: 1'b0, sub: 1'b0, sgn: 1'b1};
      FN_MSUB:  op = '{acc: 1'b1, sub: 1'b1, sgn: 1'b1};
      FN_MSUBU: op = '{acc: 1'b1, sub: 1'b1, sgn: 1'b0};
      default:  valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/mac_mult_pipe.sv
module mac_mult_pipe
  import mac_pkg::*;
#(
  parameter int W   = 32,
  parameter int LAT = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  mac_op_t        in_op,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           busy,
  output logic           fin_valid,
  output logic           fin_acc,
  output logic           fin_sub,
  output logic [2*W-1:0] fin_prod
);

  localparam int PW = 2 * W;

  logic [LAT-1:0] vld;
  mac_op_t        op0_q;
  logic [W-1:0]   a_q, b_q;
  logic [PW-1:0]  xa, xb, prod_c;
  logic [PW-1:0]  prod_q [1:LAT-1];
  logic           acc_q  [1:LAT-1];
  logic           sub_q  [1:LAT-1];

  // Operand extension chosen per operation, full-width product mod 2^PW
  always_comb begin
    xa     = {{W{op0_q.sgn & a_q[W-1]}}, a_q};
    xb     = {{W{op0_q.sgn & b_q[W-1]}}, b_q};
    prod_c = xa * xb;
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_q   <= in_a;
      b_q   <= in_b;
      op0_q <= in_op;
    end
    prod_q[1] <= prod_c;
    acc_q[1]  <= op0_q.acc;
    sub_q[1]  <= op0_q.sub;
    for (int k = 2; k < LAT; k++) begin
      prod_q[k] <= prod_q[k-1];
      acc_q[k]  <= acc_q[k-1];
      sub_q[k]  <= sub_q[k-1];
    end
  end

  assign busy      = |vld;
  assign fin_valid = vld[LAT-1];
  assign fin_acc   = acc_q[LAT-1];
  assign fin_sub   = sub_q[LAT-1];
  assign fin_prod  = prod_q[LAT-1];

  // R2: an entering operation advances into the product stage next cycle
  p_stage_advance_r2: assert property (@(posedge clk) disable iff (rst)
    vld[0] |=> vld[1]);

  // R8: only one operation occupies the pipeline at a time
  p_single_flight_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(vld) <= 1);

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fin_valid,
  input  logic           fin_acc,
  input  logic           fin_sub,
  input  logic [2*W-1:0] fin_prod,
  input  logic           hi_wr,
  input  logic [W-1:0]   hi_wdata,
  input  logic           lo_wr,
  input  logic [W-1:0]   lo_wdata,
  output logic [W-1:0]   hi_q,
  output logic [W-1:0]   lo_q,
  output logic [W-1:0]   res_q
);

  logic [2*W-1:0] acc_now, acc_next;
  logic           commit_acc;

  assign acc_now    = {hi_q, lo_q};
  assign commit_acc = fin_valid & fin_acc;
  assign acc_next   = fin_sub ? acc_now - fin_prod : acc_now + fin_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      res_q <= '0;
    end else begin
      if (commit_acc) begin
        {hi_q, lo_q} <= acc_next;
      end else begin
        if (hi_wr) hi_q <= hi_wdata;
        if (lo_wr) lo_q <= lo_wdata;
      end
      if (fin_valid && !fin_acc) res_q <= fin_prod[W-1:0];
    end
  end

  // R1: reset leaves a zero accumulator and result
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (hi_q == '0 && lo_q == '0 && res_q == '0));

  // R10: an uncontested direct write lands on the next edge
  p_direct_hi_r10: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !commit_acc) |=> hi_q == $past(hi_wdata));
  p_direct_lo_r10: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !commit_acc) |=> lo_q == $past(lo_wdata));

  // R12: result word moves only when a multiply-to-register completes
  p_result_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !(fin_valid && !fin_acc) |=> $stable(res_q));

  // R11: no direct write can disturb HI/LO on a completing accumulate edge
  p_acc_priority_r11: assert property (@(posedge clk) disable iff (rst)
    (commit_acc && !fin_sub && fin_prod == '0) |=> $stable({hi_q, lo_q}));

endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
  import mac_pkg::*;
#(
  parameter int W   = 32,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue_i,
  input  logic [5:0]   func_i,
  input  logic [W-1:0] rs_i,
  input  logic [W-1:0] rt_i,
  input  logic         hi_wr_i,
  input  logic [W-1:0] hi_wdata_i,
  input  logic         lo_wr_i,
  input  logic [W-1:0] lo_wdata_i,
  output logic [W-1:0] result_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         busy_o
);

  localparam int CW = $clog2(LAT + 1) + 1;

  logic           dec_valid, accept;
  mac_op_t        dec_op;
  logic           fin_valid, fin_acc, fin_sub;
  logic [2*W-1:0] fin_prod;

  mac_decode i_dec (
    .func  (func_i),
    .valid (dec_valid),
    .op    (dec_op)
  );

  assign accept = issue_i & dec_valid & ~busy_o;

  mac_mult_pipe #(.W(W), .LAT(LAT)) i_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (accept),
    .in_op     (dec_op),
    .in_a      (rs_i),
    .in_b      (rt_i),
    .busy      (busy_o),
    .fin_valid (fin_valid),
    .fin_acc   (fin_acc),
    .fin_sub   (fin_sub),
    .fin_prod  (fin_prod)
  );

  mac_accum #(.W(W)) i_acc (
    .clk       (clk),
    .rst       (rst),
    .fin_valid (fin_valid),
    .fin_acc   (fin_acc),
    .fin_sub   (fin_sub),
    .fin_prod  (fin_prod),
    .hi_wr     (hi_wr_i),
    .hi_wdata  (hi_wdata_i),
    .lo_wr     (lo_wr_i),
    .lo_wdata  (lo_wdata_i),
    .hi_q      (hi_o),
    .lo_q      (lo_o),
    .res_q     (result_o)
  );

  // Length of the current busy window, used by the checks below
  logic [CW-1:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst)         busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1'b1;
    else             busy_run <= '0;
  end

  // R8: busy never outlasts the pipeline depth
  p_busy_bounded_r8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> busy_run < CW'(LAT));

  // R8: every busy window is exactly LAT cycles long
  p_busy_length_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> busy_run == CW'(LAT));

  // R9: an undefined code never starts the pipeline
  p_bad_code_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && issue_i && !dec_valid) |=> !busy_o);

endmodule

// File: tb/test_mac_hilo_unit.sv
module test_mac_hilo_unit;

  localparam logic [5:0] C_MADD  = 6'b000000;
  localparam logic [5:0] C_MADDU = 6'b000001;
  localparam logic [5:0] C_MUL   = 6'b000010;
  localparam logic [5:0] C_MSUB  = 6'b000100;
  localparam logic [5:0] C_MSUBU = 6'b000101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [5:0]  func_i = '0;
  logic [31:0] rs_i = '0, rt_i = '0;
  logic        hi_wr_i = 1'b0, lo_wr_i = 1'b0;
  logic [31:0] hi_wdata_i = '0, lo_wdata_i = '0;
  logic [31:0] result_o, hi_o, lo_o;
  logic        busy_o;

  always #10 clk = ~clk;

  mac_hilo_unit i_mac_hilo_unit (
    .clk(clk), .rst(rst), .issue_i(issue_i), .func_i(func_i),
    .rs_i(rs_i), .rt_i(rt_i),
    .hi_wr_i(hi_wr_i), .hi_wdata_i(hi_wdata_i),
    .lo_wr_i(lo_wr_i), .lo_wdata_i(lo_wdata_i),
    .result_o(result_o), .hi_o(hi_o), .lo_o(lo_o), .busy_o(busy_o)
  );

  typedef struct {
    bit          is_mul;
    logic [31:0] hi, lo, res;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 0;
  logic [31:0] m_hi = '0, m_lo = '0, m_res = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] product(input logic [5:0] f,
                                          input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sp;
    if (f == C_MADDU || f == C_MSUBU) return {32'h0, a} * {32'h0, b};
    sp = $signed(a) * $signed(b);
    return sp;
  endfunction

  // Driver: computes the expected outcome and pushes it before issuing
  task automatic push_expect(input logic [5:0] f, input logic [31:0] a,
                             input logic [31:0] b, input string tag);
    exp_t e;
    logic [63:0] p, acc;
    p = product(f, a, b);
    acc = {m_hi, m_lo};
    e.is_mul = (f == C_MUL);
    if (f == C_MUL) m_res = p[31:0];
    else if (f == C_MSUB || f == C_MSUBU) acc = acc - p;
    else acc = acc + p;
    if (f != C_MUL) {m_hi, m_lo} = acc;
    e.hi = m_hi; e.lo = m_lo; e.res = m_res; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic run_op(input logic [5:0] f, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
    push_expect(f, a, b, tag);
    @(negedge clk);
    issue_i = 1'b1; func_i = f; rs_i = a; rt_i = b;
    @(negedge clk);
    issue_i = 1'b0;
    wait_idle();
  endtask

  task automatic load_hilo(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    hi_wr_i = 1'b1; hi_wdata_i = h; lo_wr_i = 1'b1; lo_wdata_i = l;
    @(negedge clk);
    hi_wr_i = 1'b0; lo_wr_i = 1'b0;
    m_hi = h; m_lo = l;
  endtask

  // Monitor: on each busy window end, pop and compare
  int bcnt = 0;
  bit prev_busy = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o) bcnt++;
      else if (prev_busy) begin
        check(bcnt == 3, "R8 busy window length", 64'(bcnt), 64'd3);
        if (sbq.size() == 0) check(0, "R8 unexpected completion", 64'd1, 64'd0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          check(result_o == e.res, {e.tag, " result"}, 64'(result_o), 64'(e.res));
          if (!e.is_mul)
            check({hi_o, lo_o} == {e.hi, e.lo}, {e.tag, " hi/lo"},
                  {hi_o, lo_o}, {e.hi, e.lo});
        end
        bcnt = 0;
      end
      prev_busy = busy_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: values held under reset
    check({hi_o, lo_o, result_o} == '0 && !busy_o, "R1 reset state",
          {hi_o, lo_o}, 64'd0);
    rst = 1'b0;

    // R2: signed MUL with negative operands
    run_op(C_MUL, 32'hFFFF_FFFD, 32'h0000_0007, "R2 mul neg*pos");
    run_op(C_MUL, 32'h8000_0000, 32'hFFFF_FFFF, "R2 mul min*-1");
    load_hilo(32'h0000_0010, 32'h0000_0020);

    // R3/R4: signed vs unsigned accumulate of the same bits
    run_op(C_MADD,  32'hFFFF_FFFF, 32'h0000_0002, "R3 madd signed");
    run_op(C_MADDU, 32'hFFFF_FFFF, 32'h0000_0002, "R4 maddu unsigned");
    // R12: accumulate left result_o at the last MUL value (checked in monitor)
    // R5/R6: signed vs unsigned subtract
    run_op(C_MSUB,  32'h8000_0000, 32'h0000_0003, "R5 msub signed");
    run_op(C_MSUBU, 32'h8000_0000, 32'h0000_0003, "R6 msubu unsigned");

    // R7: wrap upward and downward
    load_hilo(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(C_MADDU, 32'h1, 32'h1, "R7 wrap up");
    run_op(C_MSUBU, 32'h1, 32'h1, "R7 wrap down");
    run_op(C_MADD, 32'h0000_0001, 32'hFFFF_FFFF, "R7 carry into HI");

    // R8: second issue during busy is ignored
    push_expect(C_MADD, 32'h0000_0100, 32'h0000_0100, "R8 first op kept");
    @(negedge clk);
    issue_i = 1'b1; func_i = C_MADD; rs_i = 32'h100; rt_i = 32'h100;
    @(negedge clk);
    func_i = C_MSUB; rs_i = 32'h7; rt_i = 32'h7;
    @(negedge clk);
    issue_i = 1'b0;
    wait_idle();
    repeat (2) @(negedge clk);
    check(!busy_o && sbq.size() == 0, "R8 no trailing op", 64'(busy_o), 64'd0);

    // R9: unused function codes
    @(negedge clk);
    issue_i = 1'b1; func_i = 6'b000011; rs_i = 32'h5; rt_i = 32'h5;
    @(negedge clk);
    issue_i = 1'b0;
    check(!busy_o, "R9 code 000011 no busy", 64'(busy_o), 64'd0);
    @(negedge clk);
    issue_i = 1'b1; func_i = 6'b100000;
    @(negedge clk);
    issue_i = 1'b0;
    check(!busy_o, "R9 code 100000 no busy", 64'(busy_o), 64'd0);
    check({hi_o, lo_o} == {m_hi, m_lo} && result_o == m_res, "R9 state unchanged",
          {hi_o, lo_o}, {m_hi, m_lo});

    // R10: single-half direct writes
    @(negedge clk);
    hi_wr_i = 1'b1; hi_wdata_i = 32'hA5A5_0001;
    @(negedge clk);
    hi_wr_i = 1'b0; m_hi = 32'hA5A5_0001;
    check({hi_o, lo_o} == {m_hi, m_lo}, "R10 hi only", {hi_o, lo_o}, {m_hi, m_lo});
    @(negedge clk);
    lo_wr_i = 1'b1; lo_wdata_i = 32'h0000_5A5A;
    @(negedge clk);
    lo_wr_i = 1'b0; m_lo = 32'h0000_5A5A;
    check({hi_o, lo_o} == {m_hi, m_lo}, "R10 lo only", {hi_o, lo_o}, {m_hi, m_lo});

    // R11: direct write on the completion edge loses
    push_expect(C_MADDU, 32'h0000_1000, 32'h0000_0010, "R11 accumulate wins");
    @(negedge clk);
    issue_i = 1'b1; func_i = C_MADDU; rs_i = 32'h1000; rt_i = 32'h10;
    @(negedge clk);
    issue_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    hi_wr_i = 1'b1; hi_wdata_i = 32'hDEAD_BEEF;
    lo_wr_i = 1'b1; lo_wdata_i = 32'hCAFE_F00D;
    @(negedge clk);
    hi_wr_i = 1'b0; lo_wr_i = 1'b0;
    wait_idle();
    @(negedge clk);

    // R2: result timing, one more MUL with positive operands
    run_op(C_MUL, 32'h0001_0001, 32'h0001_0001, "R2 mul wide");
    repeat (2) @(negedge clk);
    check(sbq.size() == 0, "R8 scoreboard drained", 64'(sbq.size()), 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule